// File: doc/BRIEF.md
# Aligned Access Splitter for a Fixed Data Port

The block takes a transfer described by a byte start address, a byte count and a direction, and turns it into a series of single accesses toward a fixed data port. Each access is one byte, one halfword or one word, and the sizes are chosen so that every access is naturally aligned to its own size. When the start is unaligned, the transfer opens with a short head that reaches word alignment. Whole words follow. A short tail covers the bytes that are left.

A start pulse loads the transfer while the block is idle. The block then presents one access at a time with a valid strobe, an address, a size code and the latched direction. An access moves on only in a cycle where grant is high. A one-cycle done pulse marks the end. The block moves no data and adds no buffering. It only plans the accesses, and the same planning serves both reads and writes.

Top module: `xfer_split`

## Requirements
- R1: A start with a length of zero produces no access (acc_valid stays 0). done is high for exactly one cycle, in the cycle right after the start edge.
- R2: Whenever the current address is odd, the access presented is a byte (acc_size = 0). So a transfer with an odd start and a nonzero length opens with a byte.
- R3: When the current address is 2 modulo 4 and at least two bytes remain, the access is a halfword (acc_size = 1).
- R4: When the current address is a multiple of four and at least four bytes remain, the access is a word (acc_size = 2). The following access sits four bytes higher.
- R5: When fewer than four bytes remain at a word-aligned address, a halfword is issued if at least two bytes remain. A final byte follows if one byte remains.
- R6: Every access is naturally aligned and acc_size is never 3. Each access begins at the byte just past the previous one. The access sizes of one transfer add up to its length.
- R7: While acc_valid is high and acc_grant is low, acc_addr, acc_size and acc_write hold their values and acc_valid stays high.
- R8: A start pulse that arrives while busy is high has no effect on the transfer in progress.
- R9: done is high for exactly one cycle, in the cycle right after the grant of the last access. In that cycle busy and acc_valid are low.
- R10: acc_write equals the start_write value latched at the start, for every access of the transfer.
- R11: While reset is asserted, and right after it, acc_valid, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads a new transfer while idle |
| start_addr | input | 32 | Byte start address of the transfer |
| start_len | input | 16 | Byte length of the transfer |
| start_write | input | 1 | Direction: 1 write, 0 read |
| acc_grant | input | 1 | Accepts the access being presented |
| acc_valid | output | 1 | An access is being presented |
| acc_addr | output | 32 | Byte address of the current access |
| acc_size | output | 2 | Size code: 0 byte, 1 halfword, 2 word |
| acc_write | output | 1 | Direction of the current access |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The properties assume that acc_grant is a plain accept qualifier, sampled only when acc_valid is high. They also assume that start can arrive in any cycle, including while a transfer is running. The stimulus raises and drops grant in stall patterns and drives a stray start in the middle of transfers. It changes inputs only on the falling edge, so each value is stable at the rising edge where the block samples it. Transfer lengths stay within the 16-bit count, and addresses are kept far enough from the top of the address space that no transfer wraps around.

// File: rtl/xs_pkg.sv
`timescale 1ns/1ps
package xs_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;
endpackage

// File: rtl/xs_size_pick.sv
`timescale 1ns/1ps
module xs_size_pick #(
    parameter int LEN_W = 16
) (
    input  logic [1:0]       addr_lo,
    input  logic [LEN_W-1:0] remain,
    output xs_pkg::acc_size_e size
);
    import xs_pkg::*;

    localparam logic [LEN_W-1:0] TWO  = LEN_W'(2);
    localparam logic [LEN_W-1:0] FOUR = LEN_W'(4);

    always_comb begin
        if (addr_lo[0]) begin
            size = SZ_BYTE;
        end else if (addr_lo[1]) begin
            size = (remain >= TWO) ? SZ_HALF : SZ_BYTE;
        end else if (remain >= FOUR) begin
            size = SZ_WORD;
        end else if (remain >= TWO) begin
            size = SZ_HALF;
        end else begin
            size = SZ_BYTE;
        end
    end
endmodule

// File: rtl/xs_step.sv
`timescale 1ns/1ps
module xs_step #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  remain,
    input  xs_pkg::acc_size_e size,
    output logic [ADDR_W-1:0] addr_nxt,
    output logic [LEN_W-1:0]  remain_nxt,
    output logic              last
);
    import xs_pkg::*;

    logic [2:0] nbytes;

    always_comb begin
        case (size)
            SZ_WORD: nbytes = 3'd4;
            SZ_HALF: nbytes = 3'd2;
            default: nbytes = 3'd1;
        endcase
        addr_nxt   = addr + ADDR_W'(nbytes);
        remain_nxt = remain - LEN_W'(nbytes);
        last       = (remain == LEN_W'(nbytes));
    end
endmodule

// File: rtl/xfer_split.sv
`timescale 1ns/1ps
module xfer_split #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              start_write,
    input  logic              acc_grant,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [1:0]        acc_size,
    output logic              acc_write,
    output logic              busy,
    output logic              done
);
    import xs_pkg::*;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
    } split_st_t;

    split_st_t st_d, st_q;

    acc_size_e         cur_size;
    logic [ADDR_W-1:0] addr_nxt;
    logic [LEN_W-1:0]  remain_nxt;
    logic              last_acc;

    xs_size_pick #(.LEN_W(LEN_W)) u_pick (
        .addr_lo (st_q.addr[1:0]),
        .remain  (st_q.remain),
        .size    (cur_size)
    );

    xs_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
        .addr       (st_q.addr),
        .remain     (st_q.remain),
        .size       (cur_size),
        .addr_nxt   (addr_nxt),
        .remain_nxt (remain_nxt),
        .last       (last_acc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.addr   = start_addr;
                st_d.remain = start_len;
                st_d.write  = start_write;
                if (start_len == '0) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                end
            end
        end else if (acc_grant) begin
            st_d.addr   = addr_nxt;
            st_d.remain = remain_nxt;
            if (last_acc) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_valid = st_q.busy;
    assign acc_addr  = st_q.addr;
    assign acc_size  = cur_size;
    assign acc_write = st_q.write;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
endmodule

// File: rtl/xfer_split_chk.sv
`timescale 1ns/1ps
module xfer_split_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_grant,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic              acc_write,
    input logic              busy,
    input logic              done
);
    // R6
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_size != 2'd3));

    // R6
    natural_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ((acc_size == 2'd0) ||
                       (acc_size == 2'd1 && !acc_addr[0]) ||
                       (acc_size == 2'd2 && acc_addr[1:0] == 2'b00)));

    // R6
    contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_grant) |=>
            (!acc_valid || acc_addr == $past(acc_addr) + (ADDR_W'(1) << $past(acc_size))));

    // R2
    odd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[0]) |-> (acc_size == 2'd0));

    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_grant) |=>
            (acc_valid && $stable(acc_addr) && $stable(acc_size) && $stable(acc_write)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!acc_valid && !busy));
endmodule

bind xfer_split xfer_split_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_grant (acc_grant),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_write (acc_write),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_xfer_split.sv
`timescale 1ns/1ps
module test_xfer_split;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] start_len = '0;
    logic        start_write = 1'b0;
    logic        acc_grant = 1'b0;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [1:0]  acc_size;
    logic        acc_write;
    logic        busy;
    logic        done;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    xfer_split i_xfer_split (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .start_write(start_write), .acc_grant(acc_grant),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_write(acc_write), .busy(busy), .done(done)
    );

    // fields: start address, length, expected number of accesses
    localparam int NVEC = 13;
    localparam logic [55:0] VEC [NVEC] = '{
        {32'h0000_1000, 16'd0,   8'd0},
        {32'h0000_1001, 16'd1,   8'd1},
        {32'h0000_1001, 16'd7,   8'd3},
        {32'h0000_1003, 16'd10,  8'd4},
        {32'h0000_1002, 16'd3,   8'd2},
        {32'h0000_1000, 16'd8,   8'd2},
        {32'h0000_1000, 16'd7,   8'd3},
        {32'h0000_1002, 16'd1,   8'd1},
        {32'h0000_1001, 16'd2,   8'd2},
        {32'h0000_1000, 16'd2,   8'd1},
        {32'h0000_1003, 16'd1,   8'd1},
        {32'h0000_2001, 16'd16,  8'd6},
        {32'h0000_0000, 16'd100, 8'd25}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_size(input logic [31:0] a, input int n);
        if (a[0]) return 2'd0;
        if (a[1]) return (n >= 2) ? 2'd1 : 2'd0;
        if (n >= 4) return 2'd2;
        if (n >= 2) return 2'd1;
        return 2'd0;
    endfunction

    function automatic string size_tag(input logic [31:0] a, input int n);
        if (a[0]) return "R2";
        if (a[1] && n >= 2) return "R3";
        if (n >= 4) return "R4";
        return "R5";
    endfunction

    task automatic run_xfer(input logic [31:0] addr, input int len, input bit wr,
                            input int nexp, input bit stall);
        logic [31:0] m_a;
        int          m_n;
        int          cnt;
        int          cyc;
        bit          fin;
        bit          injected;
        bit          after_inject;
        bit          was_stalled;
        bit          g;
        string       tag;
        logic [1:0]  es;
        @(negedge clk);
        start = 1'b1; start_addr = addr; start_len = 16'(len); start_write = wr;
        @(negedge clk);
        start = 1'b0;
        if (len == 0) begin
            check(done == 1'b1, "R1 done after zero-length start", done, 1);
            check(acc_valid == 1'b0, "R1 no access", acc_valid, 0);
            @(negedge clk);
            check(done == 1'b0, "R1 done single cycle", done, 0);
            check(acc_valid == 1'b0, "R1 still no access", acc_valid, 0);
            return;
        end
        m_a = addr; m_n = len; cnt = 0; cyc = 0; fin = 0;
        injected = 0; after_inject = 0; was_stalled = 0;
        while (!fin && cyc < 2000) begin
            es  = exp_size(m_a, m_n);
            tag = after_inject ? "R8" : (was_stalled ? "R7" : size_tag(m_a, m_n));
            check(acc_valid == 1'b1, {tag, " valid"}, acc_valid, 1);
            check(done == 1'b0, "R9 no early done", done, 0);
            check(acc_addr == m_a, {tag, " address"}, acc_addr, m_a);
            check(acc_size == es, {tag, " size"}, acc_size, es);
            check(acc_write == wr, "R10 direction", acc_write, wr);
            after_inject = 0;
            g = stall ? (cyc % 3 != 1) : 1'b1;
            acc_grant = g;
            if (cnt == 1 && !injected) begin
                start = 1'b1; start_addr = 32'h0000_0055; start_len = 16'd3; start_write = ~wr;
                injected = 1; after_inject = 1;
            end
            @(negedge clk);
            acc_grant = 1'b0; start = 1'b0;
            if (g) begin
                m_a = m_a + (32'd1 << es);
                m_n = m_n - (1 << es);
                cnt++;
                if (m_n == 0) fin = 1;
            end
            was_stalled = !g;
            cyc++;
        end
        check(done == 1'b1, "R9 done after last grant", done, 1);
        check(acc_valid == 1'b0, "R9 valid low at done", acc_valid, 0);
        check(busy == 1'b0, "R9 busy low at done", busy, 0);
        check(cnt == nexp, "R6 access count", cnt, nexp);
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(acc_valid == 1'b0, "R11 valid in reset", acc_valid, 0);
        check(busy == 1'b0, "R11 busy in reset", busy, 0);
        check(done == 1'b0, "R11 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(acc_valid == 1'b0, "R11 valid after reset", acc_valid, 0);
        check(done == 1'b0, "R11 done after reset", done, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_xfer(VEC[i][55:24], int'(VEC[i][23:8]), i[0], int'(VEC[i][7:0]), i[1]);
        end

        // reset in the middle of a transfer
        @(negedge clk);
        start = 1'b1; start_addr = 32'h0000_0100; start_len = 16'd40; start_write = 1'b1;
        @(negedge clk);
        start = 1'b0; acc_grant = 1'b1;
        repeat (3) @(negedge clk);
        acc_grant = 1'b0;
        rst_n = 1'b0;
        #1;
        check(acc_valid == 1'b0, "R11 valid after mid-transfer reset", acc_valid, 0);
        check(busy == 1'b0, "R11 busy after mid-transfer reset", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R11 no done after reset", done, 0);
        run_xfer(32'h0000_3002, 11, 1'b0, 4, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule